// File: doc/BRIEF.md
# Floating-Point Register File with Producer Tags

This block holds a small set of floating-point architectural registers for an out-of-order core that renames registers dynamically. Each entry stores a value, a pending flag and the tag of the in-flight instruction that will next write it. A tag identifies the station or buffer holding that producer, so every value still being computed has its own name.

At dispatch the block serves two source reads at once. For each operand it returns either the ready value or the producer tag that the consumer must wait for. The same dispatch may name a destination register. That register then records the new producer's tag and becomes pending, even if an older write to it has not finished yet.

The block also watches a single result bus that carries a tag and a value. A pending register accepts the value only when the bus tag equals its own stored tag. Because of this rule, a result from a superseded producer never lands, and write-after-write hazards go away without any stall. Source reads made in the same cycle as a matching broadcast get the broadcast value directly.

Top module: `fp_rename_regfile`

## Requirements
- R1: After reset every register reads as ready with value zero and tag zero.
- R2: Reading a register that is not pending gives ready=1, its stored value on the data output, and tag 0.
- R3: Reading a pending register with no matching broadcast in that cycle gives ready=0, its producer tag on the tag output, and zero on the data output.
- R4: When a dispatch writes a destination with a nonzero tag, the register reads as pending with that tag from the next cycle on. This replaces any older pending tag. A read of that register in the dispatch cycle itself still shows the earlier state.
- R5: When a broadcast (valid, nonzero tag) carries the tag a register is waiting on, the register reads as ready with the broadcast value from the next cycle on.
- R6: When a broadcast carries a tag other than the one a register is waiting on, that register ignores it. It stays pending with its own tag, and other registers are unaffected.
- R7: When a read selects a pending register whose tag matches the broadcast in the same cycle, the read returns ready=1, the broadcast value and tag 0.
- R8: When a dispatch gives a register a new tag in the same cycle that a broadcast matches its old tag, the register stays pending with the new tag. Reads made in that cycle still receive the broadcast value as ready.
- R9: The following leave register state unchanged: a broadcast with the valid input low, a broadcast whose tag is 0 ("no producer"), and a destination write whose tag is 0. A register that is not pending is never changed by any broadcast.
- R10: The two read ports are independent. Both may select the same register, or different ones, in the same cycle and return correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_a_idx | input | 2 | Register selected by read port A |
| src_b_idx | input | 2 | Register selected by read port B |
| dst_we | input | 1 | Dispatch names a destination register this cycle |
| dst_idx | input | 2 | Destination register index |
| dst_tag | input | 4 | Tag of the new producer: 1..6 load buffers, 7..9 adder stations, 10..11 multiplier stations, 0 means none |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Tag of the broadcasting producer |
| bc_data | input | 64 | Broadcast result value |
| a_ready | output | 1 | Port A operand is a value |
| a_tag | output | 4 | Port A producer tag when not ready, else 0 |
| a_data | output | 64 | Port A value when ready, else 0 |
| b_ready | output | 1 | Port B operand is a value |
| b_tag | output | 4 | Port B producer tag when not ready, else 0 |
| b_data | output | 64 | Port B value when ready, else 0 |

## Verification
The bench builds the block with its default parameters: four registers, 4-bit tags and 64-bit values. This size covers every register index and lets several registers be pending at once with tags from all three producer classes. It brings within reach the cases that matter: a stale load result arriving after its register was renamed again, a broadcast that coincides with a fresh dispatch to the same register, and both read ports selecting one register while it is being bypassed.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned DATA_W = 64;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef struct packed {
    logic  busy;
    tag_t  tag;
    data_t value;
  } slot_t;

  localparam tag_t NO_TAG = '0;
endpackage

// File: rtl/fprf_rst_sync.sv
module fprf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fprf_slot.sv
module fprf_slot
  import fprf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  tag_t  wr_tag,
  input  logic  bc_fire,
  input  tag_t  bc_tag,
  input  data_t bc_data,
  output slot_t q
);
  slot_t d;
  logic  hit;
  logic  en;

  always_comb begin
    hit = q.busy && bc_fire && (bc_tag == q.tag);
    d   = q;
    if (hit) begin
      d.value = bc_data;
      d.busy  = 1'b0;
      d.tag   = NO_TAG;
    end
    if (wr_en) begin
      d.busy = 1'b1;
      d.tag  = wr_tag;
    end
    en = hit || wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q.busy && q.tag == $past(wr_tag))); // R4

  AST_MATCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (q.busy && bc_fire && bc_tag == q.tag && !wr_en) |=>
      (!q.busy && q.value == $past(bc_data))); // R5

  AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (q.busy && !(bc_fire && bc_tag == q.tag) && !wr_en) |=>
      (q.busy && $stable(q.tag))); // R6

  AST_NEW_TAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && q.busy && bc_fire && bc_tag == q.tag) |=> q.busy); // R8

  AST_IDLE_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!q.busy && !wr_en) |=> (!q.busy && $stable(q.value))); // R9
endmodule

// File: rtl/fprf_read_port.sv
module fprf_read_port
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  slot_t [NUM_REGS-1:0] slots,
  input  logic  [IDX_W-1:0]    idx,
  input  logic                 bc_fire,
  input  tag_t                 bc_tag,
  input  data_t                bc_data,
  output logic                 ready,
  output tag_t                 tag,
  output data_t                data
);
  slot_t sel;

  always_comb begin
    sel = slots[idx];
    if (!sel.busy) begin
      ready = 1'b1;
      tag   = NO_TAG;
      data  = sel.value;
    end else if (bc_fire && bc_tag == sel.tag) begin
      ready = 1'b1;
      tag   = NO_TAG;
      data  = bc_data;
    end else begin
      ready = 1'b0;
      tag   = sel.tag;
      data  = '0;
    end
  end

  always_comb begin
    if (ready) AST_READY_HAS_NO_TAG: assert (tag == NO_TAG); // R7
  end
endmodule

// File: rtl/fp_rename_regfile.sv
module fp_rename_regfile
  import fprf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  input  logic             dst_we,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [TAG_W-1:0] dst_tag,
  input  logic             bc_valid,
  input  logic [TAG_W-1:0] bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic             a_ready,
  output logic [TAG_W-1:0] a_tag,
  output logic [DATA_W-1:0] a_data,
  output logic             b_ready,
  output logic [TAG_W-1:0] b_tag,
  output logic [DATA_W-1:0] b_data
);
  logic                 rst_n_int;
  logic                 bc_fire;
  logic                 wr_ok;
  slot_t [NUM_REGS-1:0] slots;

  fprf_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  assign bc_fire = bc_valid && (bc_tag != NO_TAG);
  assign wr_ok   = dst_we && (dst_tag != NO_TAG);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic sel_wr;
    assign sel_wr = wr_ok && (dst_idx == IDX_W'(g));
    fprf_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .wr_en   (sel_wr),
      .wr_tag  (dst_tag),
      .bc_fire (bc_fire),
      .bc_tag  (bc_tag),
      .bc_data (bc_data),
      .q       (slots[g])
    );
  end

  fprf_read_port #(.NUM_REGS(NUM_REGS)) u_rd_a (
    .slots   (slots),
    .idx     (src_a_idx),
    .bc_fire (bc_fire),
    .bc_tag  (bc_tag),
    .bc_data (bc_data),
    .ready   (a_ready),
    .tag     (a_tag),
    .data    (a_data)
  );

  fprf_read_port #(.NUM_REGS(NUM_REGS)) u_rd_b (
    .slots   (slots),
    .idx     (src_b_idx),
    .bc_fire (bc_fire),
    .bc_tag  (bc_tag),
    .bc_data (bc_data),
    .ready   (b_ready),
    .tag     (b_tag),
    .data    (b_data)
  );

  AST_SAME_INDEX_AGREES: assert property (@(posedge clk) disable iff (!rst_n_int)
    (src_a_idx == src_b_idx) |-> (a_ready == b_ready && a_tag == b_tag && a_data == b_data)); // R10
endmodule

// File: tb/fp_rename_regfile_tb_top.sv
module fp_rename_regfile_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  src_a_idx, src_b_idx, dst_idx;
  logic        dst_we, bc_valid;
  logic [3:0]  dst_tag, bc_tag;
  logic [63:0] bc_data;
  logic        a_ready, b_ready;
  logic [3:0]  a_tag, b_tag;
  logic [63:0] a_data, b_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    string       req;
    logic        ar; logic [3:0] at; logic [63:0] ad;
    logic        br; logic [3:0] bt; logic [63:0] bd;
  } exp_t;
  exp_t sb_q[$];

  logic        m_busy [4];
  logic [3:0]  m_tag  [4];
  logic [63:0] m_val  [4];

  fp_rename_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_tag(dst_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .a_ready(a_ready), .a_tag(a_tag), .a_data(a_data),
    .b_ready(b_ready), .b_tag(b_tag), .b_data(b_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic predict(input logic [1:0] i, input logic bv, input logic [3:0] bt,
                         input logic [63:0] bd, output logic r, output logic [3:0] t,
                         output logic [63:0] d);
    if (!m_busy[i])                                  begin r = 1; t = 0; d = m_val[i]; end
    else if (bv && bt != 0 && bt == m_tag[i])        begin r = 1; t = 0; d = bd; end
    else                                             begin r = 0; t = m_tag[i]; d = 0; end
  endtask

  task automatic step(input string req, input logic [1:0] a, input logic [1:0] b,
                      input logic we, input logic [1:0] di, input logic [3:0] dt,
                      input logic bv, input logic [3:0] bt, input logic [63:0] bd);
    exp_t e;
    @(negedge clk);
    src_a_idx = a; src_b_idx = b;
    dst_we = we; dst_idx = di; dst_tag = dt;
    bc_valid = bv; bc_tag = bt; bc_data = bd;
    e.req = req;
    predict(a, bv, bt, bd, e.ar, e.at, e.ad);
    predict(b, bv, bt, bd, e.br, e.bt, e.bd);
    sb_q.push_back(e);
    for (int k = 0; k < 4; k++) begin
      if (m_busy[k] && bv && bt != 0 && bt == m_tag[k]) begin
        m_busy[k] = 0; m_val[k] = bd; m_tag[k] = 0;
      end
    end
    if (we && dt != 0) begin m_busy[di] = 1; m_tag[di] = dt; end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (a_ready !== e.ar || a_tag !== e.at || a_data !== e.ad ||
            b_ready !== e.br || b_tag !== e.bt || b_data !== e.bd) begin
          failures++;
          $display("FAIL %s: actual A=%0b/%0d/%h B=%0b/%0d/%h expected A=%0b/%0d/%h B=%0b/%0d/%h",
                   e.req, a_ready, a_tag, a_data, b_ready, b_tag, b_data,
                   e.ar, e.at, e.ad, e.br, e.bt, e.bd);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    for (int k = 0; k < 4; k++) begin m_busy[k] = 0; m_tag[k] = 0; m_val[k] = 0; end
    rst_n = 0; src_a_idx = 0; src_b_idx = 0; dst_we = 0; dst_idx = 0; dst_tag = 0;
    bc_valid = 0; bc_tag = 0; bc_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state on all four registers
    step("R1", 0, 1, 0, 0, 0, 0, 0, 0);
    step("R1", 2, 3, 0, 0, 0, 0, 0, 0);
    // R4 dispatch r0 <- load1; same-cycle read sees old ready state (R2)
    step("R2", 0, 1, 1, 0, 4'd1, 0, 0, 0);
    // R3 pending read; R4 rename r0 again to load2
    step("R3", 0, 1, 1, 0, 4'd2, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 stale load1 result arrives: ignored
    step("R6", 0, 1, 0, 0, 0, 1, 4'd1, 64'h1111_0000_0000_0001);
    step("R6", 0, 2, 0, 0, 0, 0, 0, 0);
    // R7 and R10 bypass on both ports for load2
    step("R7", 0, 0, 0, 0, 0, 1, 4'd2, 64'h2222_0000_0000_0002);
    // R5 value landed; R2 ready read
    step("R5", 0, 1, 0, 0, 0, 0, 0, 0);
    // R8 adder tag 7 on r1, then broadcast 7 while renaming r1 to multiplier 10
    step("R4", 1, 0, 1, 1, 4'd7, 0, 0, 0);
    step("R8", 1, 0, 1, 1, 4'd10, 1, 4'd7, 64'h7777_0000_0000_0007);
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0);
    // R9 valid low with matching tag ignored
    step("R9", 1, 1, 0, 0, 0, 0, 4'd10, 64'hdead_beef_0000_0000);
    step("R9", 1, 0, 0, 0, 0, 0, 0, 0);
    // R9 destination write with tag 0 ignored; broadcast tag 0 ignored on ready r0
    step("R9", 2, 0, 1, 2, 4'd0, 1, 4'd0, 64'hbad0_bad0_bad0_bad0);
    step("R9", 2, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 1, 0, 0, 0, 1, 4'd10, 64'h000a_000a_000a_000a);
    step("R5", 1, 0, 0, 0, 0, 0, 0, 0);
    // R10 two registers pending, only r3 matches
    step("R10", 2, 3, 1, 2, 4'd8, 0, 0, 0);
    step("R10", 2, 3, 1, 3, 4'd11, 0, 0, 0);
    step("R6", 2, 3, 0, 0, 0, 1, 4'd11, 64'h0b0b_0b0b_0b0b_0b0b);
    step("R6", 2, 3, 0, 0, 0, 0, 0, 0);
    step("R5", 3, 2, 0, 0, 0, 1, 4'd8, 64'h0808_0808_0808_0808);
    step("R2", 2, 3, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule